// File: doc/BRIEF.md
# Duty-Cycle Code Interpolator

This block lets a 16-bit converter core reach 18-bit effective resolution. An 18-bit code is loaded with a one-cycle strobe. Its upper sixteen bits become a base level C. Its two lowest bits become a fraction N. The block then drives the core with C or C+1 in a repeating pattern, so that the time-average of the core code equals the 18-bit level. The pattern is built from interpolation periods. Each period is split into four equal slots, and C+1 occupies the first N slots.

The slot length is a parameter counted in system clock cycles. The default of 1250 cycles per slot at a 50 MHz clock gives a 10 kHz period. A loaded code is held pending and is only committed at a period boundary, so every period is built from a single code. A phase output tells downstream logic whether the incremented level is currently selected.

Top module: `code_interp`

## Requirements
- R1: The loaded 18-bit code splits into base C = code[17:2] and fraction N = code[1:0]. For example, code 4094 gives C = 1023 and N = 2, and code 4096 gives C = 1024 and N = 0.
- R2: A period is 4 slots of SLOT_CYCLES clock cycles each. The first period starts on the first cycle after reset is released, and periods then follow back to back.
- R3: During slot s of a period (s = 0..3), `core_code` is C+1 and `hi_phase` is 1 when s < N. Otherwise `core_code` is C and `hi_phase` is 0. This gives C+1 duty cycles of 0%, 25%, 50% and 75% for N = 0, 1, 2 and 3.
- R4: With N = 0, `core_code` equals C and `hi_phase` is 0 for the whole period.
- R5: A code loaded in any cycle of a period first appears on the outputs in the first cycle of the next period. Until then, the outputs keep following the previous code.
- R6: When several loads fall in one period, including a load in its final cycle, the last one is the code used in the next period.
- R7: When C is 0xFFFF, the incremented level saturates at 0xFFFF. `hi_phase` still follows R3.
- R8: While reset is asserted and after it is released, the active code is zero, so `core_code` is 0 and `hi_phase` is 0 until a loaded code takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_valid | input | 1 | One-cycle strobe that captures `load_code` |
| load_code | input | 18 | 18-bit code: base in [17:2], fraction in [1:0] |
| core_code | output | 16 | Code driven to the converter core |
| hi_phase | output | 1 | High while the incremented level is selected |

## Verification
The bench builds the block with SLOT_CYCLES = 3, which gives a 12-cycle period. This makes it cheap to walk every slot of every period, cycle by cycle. Every fraction value is swept against bases at zero, small values, mid-range, and the two top codes, which reaches the saturation case. Loads are placed at each position in the period, including the final cycle, and several loads are placed in a single period. This shows that codes commit only at period boundaries.

// File: rtl/interp_pkg.sv
package interp_pkg;
    localparam int CODE_W = 18;
    localparam int FRAC_W = 2;
    localparam int BASE_W = CODE_W - FRAC_W;
    localparam int SLOTS  = 1 << FRAC_W;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [FRAC_W-1:0] frac;
    } icode_t;

    // increment that sticks at the top code instead of wrapping
    function automatic logic [BASE_W-1:0] sat_inc(input logic [BASE_W-1:0] v);
        return (&v) ? v : v + BASE_W'(1);
    endfunction
endpackage

// File: rtl/slot_timer.sv
module slot_timer #(
    parameter int SLOT_CYCLES = 1250,
    localparam int CW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    output logic [CW-1:0]                 cyc_cnt,
    output logic [interp_pkg::FRAC_W-1:0] slot_idx,
    output logic                          period_end
);
    import interp_pkg::*;

    logic slot_end;

    assign slot_end   = (cyc_cnt == CW'(SLOT_CYCLES - 1));
    assign period_end = slot_end && (&slot_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_cnt  <= '0;
            slot_idx <= '0;
        end else if (slot_end) begin
            cyc_cnt  <= '0;
            slot_idx <= slot_idx + FRAC_W'(1);
        end else begin
            cyc_cnt  <= cyc_cnt + CW'(1);
        end
    end
endmodule

// File: rtl/code_stage.sv
module code_stage (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load_valid,
    input  logic [interp_pkg::CODE_W-1:0] load_code,
    input  logic                          period_end,
    output interp_pkg::icode_t            act_code
);
    import interp_pkg::*;

    icode_t pend_code;
    icode_t next_pend;

    assign next_pend = load_valid ? icode_t'(load_code) : pend_code;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_code <= '0;
            act_code  <= '0;
        end else begin
            pend_code <= next_pend;
            if (period_end)
                act_code <= next_pend;
        end
    end
endmodule

// File: rtl/level_mux.sv
module level_mux (
    input  interp_pkg::icode_t               act_code,
    input  logic [interp_pkg::FRAC_W-1:0]    slot_idx,
    output logic [interp_pkg::BASE_W-1:0]    core_code,
    output logic                             hi_phase
);
    import interp_pkg::*;

    logic use_hi;

    assign use_hi    = (slot_idx < act_code.frac);
    assign hi_phase  = use_hi;
    assign core_code = use_hi ? sat_inc(act_code.base) : act_code.base;
endmodule

// File: rtl/code_interp.sv
module code_interp #(
    parameter int SLOT_CYCLES = 1250,
    localparam int CW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load_valid,
    input  logic [interp_pkg::CODE_W-1:0] load_code,
    output logic [interp_pkg::BASE_W-1:0] core_code,
    output logic                          hi_phase
);
    import interp_pkg::*;

    logic [CW-1:0]     cyc_cnt;
    logic [FRAC_W-1:0] slot_idx;
    logic              period_end;
    icode_t            act_code;

    slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .cyc_cnt    (cyc_cnt),
        .slot_idx   (slot_idx),
        .period_end (period_end)
    );

    code_stage u_stage (
        .clk        (clk),
        .rst        (rst),
        .load_valid (load_valid),
        .load_code  (load_code),
        .period_end (period_end),
        .act_code   (act_code)
    );

    level_mux u_mux (
        .act_code   (act_code),
        .slot_idx   (slot_idx),
        .core_code  (core_code),
        .hi_phase   (hi_phase)
    );
endmodule

// File: rtl/interp_checks.sv
module interp_checks #(
    parameter int SLOT_CYCLES = 1250,
    localparam int CW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1
) (
    input logic                          clk,
    input logic                          rst,
    input logic [interp_pkg::BASE_W-1:0] core_code,
    input logic                          hi_phase,
    input interp_pkg::icode_t            act_code,
    input logic [CW-1:0]                 cyc_cnt,
    input logic [interp_pkg::FRAC_W-1:0] slot_idx,
    input logic                          period_end
);
    import interp_pkg::*;

    // R2: the slot counter wraps after its last cycle
    assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (cyc_cnt == CW'(SLOT_CYCLES - 1)) |=> (cyc_cnt == '0));

    // R5: the active code only changes across a period boundary
    assert_commit_boundary_R5: assert property (@(posedge clk) disable iff (rst)
        !period_end |=> $stable(act_code));

    // R3: the incremented level only begins at the start of a period
    assert_hi_leads_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(hi_phase) |-> (cyc_cnt == '0 && slot_idx == '0));

    // R4: a zero fraction never selects the incremented level
    assert_zero_frac_R4: assert property (@(posedge clk) disable iff (rst)
        (act_code.frac == '0) |-> !hi_phase);

    // R7: the top base code never wraps
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (&act_code.base) |-> (&core_code));

    // R8: after reset the active code is cleared
    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (act_code == '0));
endmodule

bind code_interp interp_checks #(.SLOT_CYCLES(SLOT_CYCLES)) u_checks (
    .clk        (clk),
    .rst        (rst),
    .core_code  (core_code),
    .hi_phase   (hi_phase),
    .act_code   (act_code),
    .cyc_cnt    (cyc_cnt),
    .slot_idx   (slot_idx),
    .period_end (period_end)
);

// File: tb/tb_code_interp.sv
`timescale 1ns/1ps
module tb_code_interp;
    localparam int SC  = 3;
    localparam int PER = 4 * SC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_valid = 1'b0;
    logic [17:0] load_code = '0;
    logic [15:0] core_code;
    logic        hi_phase;

    int checks = 0;
    int fails  = 0;
    int pos    = 0;
    int cyc    = 0;
    bit done   = 1'b0;
    logic [17:0] cur = '0;

    always #10 clk = ~clk;

    code_interp #(.SLOT_CYCLES(SC)) dut (
        .clk        (clk),
        .rst        (rst),
        .load_valid (load_valid),
        .load_code  (load_code),
        .core_code  (core_code),
        .hi_phase   (hi_phase)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            fails++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 50000)", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
        pos = (pos + 1) % PER;
    endtask

    task automatic check(input logic [17:0] code, input string tag);
        logic [15:0] base, exp_code;
        int          fr, slot;
        logic        exp_hi;
        base     = code[17:2];
        fr       = int'(code[1:0]);
        slot     = pos / SC;
        exp_hi   = (slot < fr);
        exp_code = exp_hi ? ((base == 16'hFFFF) ? 16'hFFFF : base + 16'd1) : base;
        checks++;
        if (core_code !== exp_code || hi_phase !== exp_hi) begin
            fails++;
            $display("FAIL %s code=%h pos=%0d: actual core=%h hi=%b expected core=%h hi=%b",
                     tag, code, pos, core_code, hi_phase, exp_code, exp_hi);
        end
    endtask

    function automatic string tag_of(input logic [17:0] code);
        if (code[17:2] == 16'hFFFF) return "R7";
        if (code[1:0] == 2'd0)      return "R4";
        return "R3";
    endfunction

    // load at position lpos, check old code until boundary, then a full period of new
    task automatic run_code(input logic [17:0] code, input int lpos, input string tag);
        while (pos != lpos) begin
            tick();
            check(cur, "R5");
        end
        load_valid = 1'b1;
        load_code  = code;
        tick();
        load_valid = 1'b0;
        while (pos != 0) begin
            check(cur, "R5");
            tick();
        end
        cur = code;
        for (int k = 0; k < PER; k++) begin
            check(cur, tag);
            tick();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(18'd0, "R8");
        rst = 1'b0;
        pos = 0;
        // R8 / R2: a full idle period of zero after reset
        for (int k = 0; k < PER; k++) begin
            check(18'd0, "R8");
            tick();
        end

        // R1: worked examples around a base carry
        for (int c = 4092; c <= 4096; c++)
            run_code(18'(c), c % PER, "R1");

        // R3/R4/R7: every fraction against a set of bases, load position varied
        begin
            logic [15:0] bases [6] = '{16'h0000, 16'h0001, 16'h03FF, 16'h7FFF, 16'hFFFE, 16'hFFFF};
            int n = 0;
            foreach (bases[i]) begin
                for (int f = 0; f < 4; f++) begin
                    logic [17:0] c;
                    c = {bases[i], 2'(f)};
                    run_code(c, (n * 5) % PER, tag_of(c));
                    n++;
                end
            end
        end

        // R5: load in the last cycle of a period takes effect right after it
        run_code(18'h2AAA9, PER - 1, "R5");

        // R6: three loads in one period, last (in the final cycle) wins
        while (pos != 2) begin tick(); check(cur, "R5"); end
        load_valid = 1'b1; load_code = 18'h11112; tick(); load_valid = 1'b0;
        while (pos != 7) begin check(cur, "R6"); tick(); end
        load_valid = 1'b1; load_code = 18'h22223; tick(); load_valid = 1'b0;
        while (pos != PER - 1) begin check(cur, "R6"); tick(); end
        load_valid = 1'b1; load_code = 18'h05431; tick(); load_valid = 1'b0;
        cur = 18'h05431;
        for (int k = 0; k < PER; k++) begin
            check(cur, "R6");
            tick();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule